// File: doc/BRIEF.md
# Embedded operation status reporter

This block forms the word a host sees when it reads the flash array. While an internal program or erase is running, the block does not return array contents. Instead, two bits report progress. The poll bit (bit 7) reports which kind of operation is in flight. The toggle bit (bit 6) inverts on every new read access, so a host can tell the operation is still running. While identification mode is active, the block returns the fixed vendor code, the fixed device code, or the boot-lock status, depending on the address. In every other case, array data passes through unchanged.

The timing of the embedded operation itself lies outside this block, and so do the bidirectional output drivers. The caller supplies these inputs:
- a busy flag,
- the operation kind,
- the word last loaded for programming,
- a read strobe and a read address,
- the identification-mode and boot-lock flags,
- the raw array data.

All of these are plain level signals. Reads cannot be refused, so there is no valid/ready handshake and no back-pressure. The result is registered and appears one clock after the inputs are sampled.

Top module: `poll_status_reporter`

## Requirements
- R1: While `busy` is high and `op_is_erase` is low (program), bit 7 of the read word is the inverse of bit 7 of `last_word`.
- R2: While `busy` is high and `op_is_erase` is high (chip or sector erase), bit 7 of the read word is 0.
- R3: While busy, bit 6 inverts once for each rising edge of `rd_strobe`. A strobe held high for several clocks leaves bit 6 unchanged. A strobe edge seen while not busy does not advance it.
- R4: When neither busy nor in identification mode, the read word equals `array_data` on all 16 bits. This includes the first read after an operation finishes. `boot_locked` and `rd_addr` have no effect in this case.
- R5: In identification mode with busy low, address 0 returns 0x001F and address 1 returns 0x0092.
- R6: In identification mode with busy low, address 2 returns the boot-lock state on bit 0 (1 = locked, 0 = programmable), with all other bits 0.
- R7: In identification mode with busy low, any address other than 0, 1 or 2 returns 0x0000. This includes addresses that differ only in their upper bits.
- R8: While busy, every bit other than bits 7 and 6 reads 0. Busy takes precedence over identification mode.
- R9: `rd_word` is a register. It shows the word built from the inputs sampled at the previous rising clock edge, and it is 0x0000 during and right after reset, with the toggle state cleared to 0.
- R10: The toggle state is not cleared when an operation ends or a new one begins, so bit 6 starts a new operation at the level the last one left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Embedded program or erase in progress |
| op_is_erase | input | 1 | 1 = erase in progress, 0 = program |
| last_word | input | 16 | Word being programmed |
| rd_strobe | input | 1 | Read access active (level) |
| rd_addr | input | 18 | Read word address |
| id_mode | input | 1 | Identification mode active |
| boot_locked | input | 1 | Boot block programming lockout enabled |
| array_data | input | 16 | Data read from the array |
| rd_word | output | 16 | Registered read word |

## Verification
The only hidden state is the toggle bit and the strobe-edge history.

A wrong toggle value shows at bit 6 on the very next read during busy. The fault is a missed inversion, a double inversion on a held strobe, or a clear at the start of an operation. A held-strobe check and a retained-across-operations check bring these out within one or two clocks.

A wrong source selection shows on the whole word one clock after the inputs change. The bench therefore drives each mode and address case and compares all sixteen bits one clock later.

// File: rtl/poll_pkg.sv
package poll_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_POLL  = 2'd1,
    SRC_IDENT = 2'd2
  } rd_src_e;

  // A running operation hides everything else; identification comes next.
  function automatic rd_src_e pick_source(input logic busy, input logic id_mode);
    if (busy)         return SRC_POLL;
    else if (id_mode) return SRC_IDENT;
    else              return SRC_ARRAY;
  endfunction

endpackage

// File: rtl/psr_edge_detect.sv
module psr_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  assign rise = level_in & ~level_q;
endmodule

// File: rtl/psr_toggle_reg.sv
module psr_toggle_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic tog_next
);
  logic tog_q;

  assign tog_next = advance ? ~tog_q : tog_q;

  // Never cleared by operation boundaries: only reset touches it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_next;
  end
endmodule

// File: rtl/psr_ident_rom.sv
module psr_ident_rom #(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 18,
  parameter int          LOCK_BIT = 0,
  parameter logic [7:0]  MFR_CODE = 8'h1F,
  parameter logic [7:0]  DEV_CODE = 8'h92
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              boot_locked,
  output logic [DATA_W-1:0] id_word
);
  localparam logic [ADDR_W-1:0] MFR_ADDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DEV_ADDR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(2);

  always_comb begin
    id_word = '0;
    if (addr == MFR_ADDR)       id_word = DATA_W'(MFR_CODE);
    else if (addr == DEV_ADDR)  id_word = DATA_W'(DEV_CODE);
    else if (addr == LOCK_ADDR) id_word[LOCK_BIT] = boot_locked;
  end
endmodule

// File: rtl/psr_word_mux.sv
module psr_word_mux
  import poll_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  rd_src_e           src,
  input  logic              op_is_erase,
  input  logic              ref_poll_bit,
  input  logic              tog,
  input  logic [DATA_W-1:0] id_word,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] word_out
);
  logic [DATA_W-1:0] poll_word;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign poll_word[b] = op_is_erase ? 1'b0 : ~ref_poll_bit;
    end else if (b == TOG_BIT) begin : g_tog
      assign poll_word[b] = tog;
    end else begin : g_zero
      assign poll_word[b] = 1'b0;
    end
  end

  always_comb begin
    unique case (src)
      SRC_POLL:  word_out = poll_word;
      SRC_IDENT: word_out = id_word;
      default:   word_out = array_data;
    endcase
  end
endmodule

// File: rtl/poll_status_reporter.sv
module poll_status_reporter
  import poll_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 18,
  parameter int          POLL_BIT = 7,
  parameter int          TOG_BIT  = 6,
  parameter int          LOCK_BIT = 0,
  parameter logic [7:0]  MFR_CODE = 8'h1F,
  parameter logic [7:0]  DEV_CODE = 8'h92
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              op_is_erase,
  input  logic [DATA_W-1:0] last_word,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              id_mode,
  input  logic              boot_locked,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_word
);
  logic              strobe_rise;
  logic              tog_next;
  logic [DATA_W-1:0] id_word;
  logic [DATA_W-1:0] next_word;
  rd_src_e           src;
  logic              unused_word_bits;

  // Only the poll bit of the programmed word is reported.
  assign unused_word_bits = ^last_word;

  psr_edge_detect u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (rd_strobe),
    .rise     (strobe_rise)
  );

  psr_toggle_reg u_tog (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (strobe_rise & busy),
    .tog_next (tog_next)
  );

  psr_ident_rom #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .LOCK_BIT (LOCK_BIT),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_rom (
    .addr        (rd_addr),
    .boot_locked (boot_locked),
    .id_word     (id_word)
  );

  assign src = pick_source(busy, id_mode);

  psr_word_mux #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TOG_BIT  (TOG_BIT)
  ) u_mux (
    .src          (src),
    .op_is_erase  (op_is_erase),
    .ref_poll_bit (last_word[POLL_BIT]),
    .tog          (tog_next),
    .id_word      (id_word),
    .array_data   (array_data),
    .word_out     (next_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_word <= '0;
    else        rd_word <= next_word;
  end
endmodule

// File: rtl/poll_status_checker.sv
module poll_status_checker #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 18,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6,
  parameter int LOCK_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              op_is_erase,
  input logic              ref_poll_bit,
  input logic              rd_strobe,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              id_mode,
  input logic              boot_locked,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_word
);
  localparam logic [DATA_W-1:0] STATUS_MASK =
    (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT);

  // Set after the first clock out of reset, so $past never reaches into reset.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_prog_poll_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_is_erase) |=> (rd_word[POLL_BIT] == ~$past(ref_poll_bit)));

  assert_erase_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_is_erase) |=> (rd_word[POLL_BIT] == 1'b0));

  assert_toggle_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && busy && $past(busy) && rd_strobe && !$past(rd_strobe))
      |=> (rd_word[TOG_BIT] != $past(rd_word[TOG_BIT])));

  assert_toggle_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && busy && $past(busy) && rd_strobe && $past(rd_strobe))
      |=> $stable(rd_word[TOG_BIT]));

  assert_passthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !id_mode) |=> (rd_word == $past(array_data)));

  assert_ident_mfr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && id_mode && rd_addr == ADDR_W'(0)) |=> (rd_word == DATA_W'(8'h1F)));

  assert_ident_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && id_mode && rd_addr == ADDR_W'(2))
      |=> (rd_word == (DATA_W'($past(boot_locked)) << LOCK_BIT)));

  assert_busy_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((rd_word & ~STATUS_MASK) == '0));
endmodule

bind poll_status_reporter poll_status_checker #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .POLL_BIT (POLL_BIT),
  .TOG_BIT  (TOG_BIT),
  .LOCK_BIT (LOCK_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .op_is_erase  (op_is_erase),
  .ref_poll_bit (last_word[POLL_BIT]),
  .rd_strobe    (rd_strobe),
  .rd_addr      (rd_addr),
  .id_mode      (id_mode),
  .boot_locked  (boot_locked),
  .array_data   (array_data),
  .rd_word      (rd_word)
);

// File: tb/poll_status_reporter_test.sv
`timescale 1ns/1ps
module poll_status_reporter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy = 1'b0;
  logic        op_is_erase = 1'b0;
  logic [15:0] last_word = '0;
  logic        rd_strobe = 1'b0;
  logic [17:0] rd_addr = '0;
  logic        id_mode = 1'b0;
  logic        boot_locked = 1'b0;
  logic [15:0] array_data = '0;
  logic [15:0] rd_word;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  poll_status_reporter uut (
    .clk (clk), .rst_n (rst_n), .busy (busy), .op_is_erase (op_is_erase),
    .last_word (last_word), .rd_strobe (rd_strobe), .rd_addr (rd_addr),
    .id_mode (id_mode), .boot_locked (boot_locked), .array_data (array_data),
    .rd_word (rd_word)
  );

  // Layout: tag byte | {busy,erase,id,lock} | addr nibble | last | array | expected
  localparam int NVEC = 14;
  localparam logic [63:0] VEC [NVEC] = '{
    64'h04_0_0_0000_A5C3_A5C3, // R4 plain pass-through
    64'h04_0_0_FFFF_0000_0000, // R4 zero data
    64'h04_1_2_0000_FFFF_FFFF, // R4 lock and address ignored
    64'h05_2_0_0000_FFFF_001F, // R5 vendor code
    64'h05_2_1_0000_FFFF_0092, // R5 device code
    64'h06_3_2_0000_FFFF_0001, // R6 locked
    64'h06_2_2_0000_FFFF_0000, // R6 programmable
    64'h07_3_3_0000_FFFF_0000, // R7 unmapped address
    64'h01_8_0_0080_FFFF_0000, // R1 bit7 set -> 0
    64'h01_8_0_0000_FFFF_0080, // R1 bit7 clear -> 1
    64'h02_C_0_0000_FFFF_0000, // R2 erase
    64'h08_A_0_0000_1234_0080, // R8 busy beats id mode
    64'h02_C_0_FF7F_FFFF_0000, // R2 erase ignores last word
    64'h08_9_2_0000_5555_0080  // R8 other bits zero
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %04h expected %04h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    array_data = 16'hFFFF;
    repeat (3) tick();
    check("R9 reset value", rd_word, 16'h0000);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] v;
      v = VEC[i];
      busy        = v[55];
      op_is_erase = v[54];
      id_mode     = v[53];
      boot_locked = v[52];
      rd_addr     = {14'd0, v[51:48]};
      last_word   = v[47:32];
      array_data  = v[31:16];
      tick();
      check($sformatf("R%0d vector %0d", v[63:56], i), rd_word, v[15:0]);
    end

    // R7: upper address bits matter
    busy = 0; id_mode = 1; rd_addr = 18'h10000; array_data = 16'hFFFF;
    tick();
    check("R7 upper address", rd_word, 16'h0000);

    // R9: one-clock latency
    id_mode = 0; array_data = 16'h1234;
    tick();
    array_data = 16'hBEEF;
    #1;
    check("R9 old value before edge", rd_word, 16'h1234);
    tick();
    check("R9 new value after edge", rd_word, 16'hBEEF);

    // R3 toggle behaviour during a program
    busy = 1; op_is_erase = 0; last_word = 16'h0000; array_data = 16'hFFFF;
    tick();
    check("R3 initial toggle", rd_word, 16'h0080);
    rd_strobe = 1;
    tick();
    check("R3 first edge", rd_word, 16'h00C0);
    tick();
    check("R3 held strobe", rd_word, 16'h00C0);
    tick();
    check("R3 held strobe again", rd_word, 16'h00C0);
    rd_strobe = 0;
    tick();
    check("R3 strobe low", rd_word, 16'h00C0);
    rd_strobe = 1;
    tick();
    check("R3 second edge", rd_word, 16'h0080);
    rd_strobe = 0;

    // R3 edges while idle do not advance
    busy = 0; array_data = 16'h0000;
    tick();
    rd_strobe = 1;
    tick();
    rd_strobe = 0;
    tick();
    check("R4 idle read", rd_word, 16'h0000);
    busy = 1;
    tick();
    check("R3 idle edge ignored", rd_word, 16'h0080);

    // R10: toggle level retained into the next operation
    rd_strobe = 1;
    tick();
    check("R3 edge to one", rd_word, 16'h00C0);
    rd_strobe = 0; busy = 0; array_data = 16'h7E81;
    tick();
    check("R4 completion true data", rd_word, 16'h7E81);
    busy = 1; op_is_erase = 1;
    tick();
    check("R10 retained toggle", rd_word, 16'h0040);
    rd_strobe = 1;
    tick();
    check("R10 erase edge", rd_word, 16'h0000);
    rd_strobe = 0;

    // R9: reset clears the toggle
    rd_strobe = 1;
    tick();
    rd_strobe = 0;
    rst_n = 0;
    tick();
    check("R9 reset mid-operation", rd_word, 16'h0000);
    rst_n = 1;
    tick();
    check("R9 toggle cleared", rd_word, 16'h0000);
    op_is_erase = 0;
    tick();
    check("R1 after reset", rd_word, 16'h0080);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule